// File: doc/BRIEF.md
# Shared Interrupt Line Aggregator

This block merges the level-sensitive interrupt pins of a set of devices onto a small group of shared interrupt lines. Every device has four pins. Each pin is assigned to one shared line by a fixed routing rule. On every clock the block samples all pin levels and compares them with the levels it holds from the previous sample.

The block keeps a counter for each shared line. A pin that rises adds one to its line's counter, and a pin that falls subtracts one. A line is high while its counter is above zero. The OR of a line's sources is never recomputed from scratch. It is carried as a running count that changes only when a source level changes.

A typical use is a host bridge that collects the interrupt pins of the devices in its slots and presents a few shared lines to an interrupt controller.

Top module: `irq_line_merge`

## Requirements
- R1: While reset is asserted, all held pin levels and all line counters are zero and every line output is low.
- R2: A sampled pin level equal to the held level for that pin has no effect. A pin held high for many cycles is counted once, so a single later fall releases its line.
- R3: When a pin rises, its line's counter goes up by one and the line goes high in the cycle after the sample edge.
- R4: When a pin falls, its line's counter goes down by one, and the line goes low once no source of that line is high.
- R5: A line output is high exactly when at least one of its held source pins is high. Its counter always equals the number of its held source pins that are high.
- R6: Pin p of device d (d counting from 0, pin bit index d*4+p of `pin_lvl`) drives line (d+p) mod NLINES.
- R7: Rises and falls on any number of pins in the same cycle are all applied in that cycle. This includes a rise and a fall on the same line, which together leave that line's count unchanged.
- R8: A counter never overflows. With every pin high, each line's counter reaches its full source count, and the line stays high until the last of its sources falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; pins are sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | NDEV*4 | Pin levels; bit d*4+p is pin p of device d |
| irq_line | output | NLINES | Shared interrupt line levels |

## Verification
The bound checker verifies on every cycle that the held pin levels follow the previous sample. It also checks that each counter equals the population count of its line's held high sources, that no counter exceeds its source count, that an unchanged sample leaves the counters untouched, and that each line output agrees with its held sources. Only the bench scenarios can show certain end-to-end results at the ports: the routing of every individual pin, a long-held pin being released by a single fall, a same-cycle swap between two sources of one line, and the sequence in which a fully loaded line drains one source at a time. The bench compares each line against an OR of the sampled pins, grouped by the routing rule.

// File: rtl/irq_line_merge.sv
module irq_line_merge #(
  parameter int NDEV   = 8,
  parameter int NLINES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NDEV*4-1:0]   pin_lvl,
  output logic [NLINES-1:0]   irq_line
);
  localparam int NPIN = NDEV * 4;
  localparam int CW   = $clog2(NPIN + 1);

  logic [NPIN-1:0]             seen_q;
  logic [NLINES-1:0][CW-1:0]   cnt_q, cnt_d;

  wire [NPIN-1:0] rise = pin_lvl & ~seen_q;
  wire [NPIN-1:0] fall = ~pin_lvl & seen_q;

  // all changes of a cycle fold into one update per line
  always_comb begin
    cnt_d = cnt_q;
    for (int d = 0; d < NDEV; d++)
      for (int p = 0; p < 4; p++)
        cnt_d[(d + p) % NLINES] = cnt_d[(d + p) % NLINES]
                                  + CW'(rise[d*4+p]) - CW'(fall[d*4+p]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
      cnt_q  <= '0;
    end else begin
      seen_q <= pin_lvl;
      cnt_q  <= cnt_d;
    end
  end

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    assign irq_line[g] = |cnt_q[g];
  end
endmodule

// File: rtl/irq_line_merge_chk.sv
module irq_line_merge_chk #(
  parameter int NDEV   = 8,
  parameter int NLINES = 4,
  parameter int CW     = $clog2(NDEV*4 + 1)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NDEV*4-1:0]          pin_lvl,
  input logic [NDEV*4-1:0]          seen_q,
  input logic [NLINES-1:0][CW-1:0]  cnt_q,
  input logic [NLINES-1:0]          irq_line
);
  localparam int NPIN = NDEV * 4;

  function automatic logic [NPIN-1:0] line_mask(input int l);
    logic [NPIN-1:0] m = '0;
    for (int d = 0; d < NDEV; d++)
      for (int p = 0; p < 4; p++)
        if ((d + p) % NLINES == l) m[d*4+p] = 1'b1;
    return m;
  endfunction

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |-> (cnt_q == '0 && seen_q == '0 && irq_line == '0));

  p_hold_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> seen_q == $past(pin_lvl));

  p_quiet_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_lvl == seen_q) |=> $stable(cnt_q));

  for (genvar g = 0; g < NLINES; g++) begin : g_chk
    localparam logic [NPIN-1:0] MASK = line_mask(g);

    p_count_tracks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt_q[g]) == $countones(seen_q & MASK));

    p_line_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_line[g] == |(seen_q & MASK));

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt_q[g]) <= $countones(MASK));
  end
endmodule

bind irq_line_merge irq_line_merge_chk #(.NDEV(NDEV), .NLINES(NLINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .seen_q(seen_q),
  .cnt_q(cnt_q), .irq_line(irq_line)
);

// File: tb/sim_irq_line_merge.sv
module sim_irq_line_merge;
  localparam int NDEV = 8;
  localparam int NL   = 4;
  localparam int NPIN = NDEV * 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b1;
  logic [NPIN-1:0] pin_lvl = '0;
  logic [NL-1:0]   irq_line;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  irq_line_merge #(.NDEV(NDEV), .NLINES(NL)) u0 (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .irq_line(irq_line)
  );

  always #10 clk = ~clk;

  function automatic logic [NL-1:0] exp_lines(input logic [NPIN-1:0] v);
    logic [NL-1:0] e = '0;
    for (int d = 0; d < NDEV; d++)
      for (int p = 0; p < 4; p++)
        if (v[d*4+p]) e[(d + p) % NL] = 1'b1;
    return e;
  endfunction

  task automatic check(input string req, input logic [NL-1:0] got, input logic [NL-1:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: irq_line=%b expected %b", req, got, exp);
    end
  endtask

  // drive at negedge, result visible after the following posedge
  task automatic step(input logic [NPIN-1:0] v, input string req);
    pin_lvl = v;
    @(negedge clk);
    check(req, irq_line, exp_lines(v));
  endtask

  initial begin
    logic [NPIN-1:0] v;
    void'($urandom(32'd4321));
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset", irq_line, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", irq_line, '0);

    // R6 / R3 / R4: each pin alone lands on (d+p) mod 4
    for (int i = 0; i < NPIN; i++) begin
      v = '0; v[i] = 1'b1;
      step(v, "R6 single pin routing");
      check("R6 one-hot line", irq_line, NL'(1) << ((i/4 + i%4) % NL));
      step('0, "R4 single pin fall");
    end

    // R5 shared line: dev0 pin0 and dev1 pin3 both feed line 0
    v = '0; v[0] = 1'b1; v[7] = 1'b1;
    step(v, "R5 two sources up");
    v[0] = 1'b0;
    step(v, "R5 one source left");
    check("R5 line0 held", irq_line, 4'b0001);
    step('0, "R4 last source down");

    // R2: long hold counted once
    v = '0; v[5] = 1'b1;
    for (int k = 0; k < 6; k++) step(v, "R2 repeated high sample");
    step('0, "R2 single fall releases");
    check("R2 line clear", irq_line, 4'b0000);

    // R7: same-cycle swap within line 0
    v = '0; v[0] = 1'b1;
    step(v, "R7 first source");
    v = '0; v[7] = 1'b1;
    step(v, "R7 swap in one cycle");
    check("R7 swap keeps line", irq_line, 4'b0001);
    step('0, "R7 swap source down");
    check("R7 cleared", irq_line, 4'b0000);

    // R8: all high, drain line 0 one source at a time
    v = '1;
    step(v, "R7 all rise together");
    check("R8 full load", irq_line, 4'b1111);
    for (int d = 0; d < NDEV; d++) begin
      v[d*4 + ((NL - d % NL) % NL)] = 1'b0;
      step(v, "R8 drain line0");
    end
    check("R8 line0 empty", irq_line[0] ? 4'b0001 : 4'b0000, 4'b0000);
    step('0, "R7 all fall together");

    // random traffic
    for (int k = 0; k < 400; k++) begin
      v = NPIN'($urandom());
      if (k % 3 == 0) v = pin_lvl ^ (NPIN'(1) << ($urandom() % NPIN));
      step(v, "R3 R4 R7 random");
    end

    // R1 mid-run reset
    step('1, "R3 load before reset");
    rst_n = 1'b0;
    pin_lvl = '0;
    @(negedge clk);
    check("R1 mid-run reset", irq_line, '0);
    rst_n = 1'b1;
    step('0, "R1 post reset idle");
    v = '0; v[2] = 1'b1;
    step(v, "R3 rise after reset");

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(20 * 150000);
        tests++; fails++;
        $display("FAIL watchdog: run hung, expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule